// File: doc/BRIEF.md
# AES-128 Block Decryption Engine with Key Preload

This engine recovers 128-bit plaintext blocks from ciphertext under a 128-bit key, using the standard AES-128 inverse cipher. Work is split into two phases, each with its own handshake. In the key phase, a single-cycle `key_load` strobe captures `key`. The engine then runs the forward key schedule one round per cycle until it reaches the round-10 key. It keeps that key in a holding register and signals completion with a one-cycle `key_done` pulse.

In the data phase, a single-cycle `load` strobe captures `text_in`. The engine then applies one inverse round per cycle. Each round needs an earlier round key, and the engine computes it on the fly by running the key schedule backwards from the held final key, so no table of eleven round keys is stored. When the last round is finished, `done` pulses for one cycle and `text_out` carries the plaintext. Any number of blocks may be decrypted after one key preload. A full key preload followed by one block takes 24 cycles.

Top module: `aes128_decrypt`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `key_done` and `done` are 0 and `text_out` is all zeros.
- R2: When `key_load` is high in cycle c and the engine is idle, `key_done` is high in cycle c+12 and only in that cycle, for one cycle.
- R3: A `load` pulse produces no `done` if no key preload has completed since reset or since the most recent accepted `key_load`.
- R4: When `load` is high in cycle c, the engine is idle and a key is ready, `done` is high in cycle c+12 for exactly one cycle. `text_out` holds its value until the next `done`.
- R5: `text_out` equals the AES-128 inverse cipher of the captured `text_in` under the preloaded key. Bits [127:120] are byte 0, state bytes fill column by column (byte i sits in row i mod 4, column i/4), and the key uses the same byte order.
- R6: After one key preload, successive blocks each decrypt correctly under that key without repeating the key phase.
- R7: A new accepted `key_load` replaces the held key. Blocks loaded after the new `key_done` decrypt under the new key.
- R8: `load` and `key_load` pulses that arrive while either phase is running are ignored. The running block completes with its original result, only one `done` occurs, and the held key is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| key | input | 128 | Cipher key, sampled with `key_load` |
| key_load | input | 1 | One-cycle strobe that starts the key phase |
| key_done | output | 1 | One-cycle pulse: final round key is ready |
| text_in | input | 128 | Ciphertext block, sampled with `load` |
| load | input | 1 | One-cycle strobe that starts a block decryption |
| done | output | 1 | One-cycle pulse: `text_out` holds new plaintext |
| text_out | output | 128 | Recovered plaintext |

## Verification
A corrupted held key or a wrong step in the reverse key schedule changes every plaintext byte. Because the rounds diffuse the error, it shows as a complete mismatch on `text_out` at the very first `done` after the fault. A round counter that is off by one moves the `key_done` or `done` pulse away from cycle c+12, or leaves a stray second pulse, so the bench measures each latency in cycles. A readiness flag that is set early or never cleared lets a `load` that should be ignored produce a `done` within 12 cycles of that `load`.

// File: rtl/aes_dec_pkg.sv
// Package: shared sizes and GF(2^8) arithmetic for the AES-128 decryption engine.
// Assumes the standard AES field polynomial x^8+x^4+x^3+x+1.
package aes_dec_pkg;
    localparam int BLK_W     = 128;
    localparam int BYTE_W    = 8;
    localparam int NUM_BYTES = BLK_W / BYTE_W;
    localparam int WORD_W    = 32;
    localparam int NUM_RND   = 10;
    localparam int CNT_W     = 4;
    localparam logic [CNT_W-1:0] LAST_RND  = CNT_W'(NUM_RND);
    localparam logic [CNT_W-1:0] FINAL_CNT = CNT_W'(NUM_RND + 1);

    // Multiply by x in GF(2^8).
    function automatic logic [7:0] xtime(input logic [7:0] a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    // General field multiply, shift-and-add.
    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] p;
        logic [7:0] x;
        p = 8'h00;
        x = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) p = p ^ x;
            x = xtime(x);
        end
        return p;
    endfunction

    // Field inverse as a^254 (maps 0 to 0).
    function automatic logic [7:0] gf_inv(input logic [7:0] a);
        logic [7:0] res;
        logic [7:0] base;
        res  = 8'h01;
        base = a;
        for (int i = 0; i < 8; i++) begin
            if (i != 0) res = gf_mul(res, base);
            base = gf_mul(base, base);
        end
        return res;
    endfunction

    function automatic logic [7:0] rotl8(input logic [7:0] a, input int n);
        return (a << n) | (a >> (8 - n));
    endfunction

    // Forward substitution: inverse then affine map.
    function automatic logic [7:0] sub_fwd(input logic [7:0] a);
        logic [7:0] v;
        v = gf_inv(a);
        return v ^ rotl8(v, 1) ^ rotl8(v, 2) ^ rotl8(v, 3) ^ rotl8(v, 4) ^ 8'h63;
    endfunction

    // Inverse substitution: inverse affine map then field inverse.
    function automatic logic [7:0] sub_inv(input logic [7:0] a);
        logic [7:0] v;
        v = rotl8(a, 1) ^ rotl8(a, 3) ^ rotl8(a, 6) ^ 8'h05;
        return gf_inv(v);
    endfunction

    // Round constant for key-schedule step i (1..10).
    function automatic logic [7:0] rcon_of(input logic [CNT_W-1:0] i);
        logic [7:0] r;
        r = 8'h01;
        for (int j = 2; j < 16; j++) begin
            if (CNT_W'(j) <= i) r = xtime(r);
        end
        return r;
    endfunction
endpackage

// File: rtl/aes_dec_keyprep.sv
// Module: key phase. Captures the cipher key on an accepted key_load, runs the
// forward key schedule one step per cycle up to the round-10 key, keeps that key
// and pulses key_done twelve cycles after the strobe.
// Assumes the top only needs 'ready' and the held final key.
module aes_dec_keyprep
    import aes_dec_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BLK_W-1:0] key,
    input  logic             key_load,
    input  logic             data_busy,
    output logic             key_done,
    output logic             ready,
    output logic             busy,
    output logic [BLK_W-1:0] final_key
);
    logic [BLK_W-1:0]  kreg;
    logic [BLK_W-1:0]  kreg_nx;
    logic [CNT_W-1:0]  kcnt;
    logic [WORD_W-1:0] w0, w1, w2, w3, n0, n1, n2, n3, rot, mixw;
    logic              accept;

    assign accept = key_load && !busy && !data_busy;
    assign {w0, w1, w2, w3} = kreg;
    assign rot = {w3[23:0], w3[31:24]};

    // Substitute each byte of the rotated last word.
    for (genvar b = 0; b < 4; b++) begin : g_sub
        assign mixw[WORD_W-1-8*b -: 8] = sub_fwd(rot[WORD_W-1-8*b -: 8]);
    end

    // One forward schedule step.
    always_comb begin
        n0 = w0 ^ mixw ^ {rcon_of(kcnt), 24'h0};
        n1 = w1 ^ n0;
        n2 = w2 ^ n1;
        n3 = w3 ^ n2;
        kreg_nx = {n0, n1, n2, n3};
    end

    // Key-phase sequencing and storage of the final round key.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kreg      <= '0;
            kcnt      <= '0;
            busy      <= 1'b0;
            ready     <= 1'b0;
            key_done  <= 1'b0;
            final_key <= '0;
        end else begin
            key_done <= 1'b0;
            if (accept) begin
                kreg  <= key;
                kcnt  <= CNT_W'(1);
                busy  <= 1'b1;
                ready <= 1'b0;
            end else if (busy) begin
                if (kcnt <= LAST_RND) kreg <= kreg_nx;
                if (kcnt == FINAL_CNT) begin
                    busy      <= 1'b0;
                    ready     <= 1'b1;
                    key_done  <= 1'b1;
                    final_key <= kreg;
                end
                kcnt <= kcnt + CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/aes_dec_keyback.sv
// Module: one reverse key-schedule step. Given round key r+1 and the round
// constant of step r+1, returns round key r. Purely combinational.
module aes_dec_keyback
    import aes_dec_pkg::*;
(
    input  logic [BLK_W-1:0] rk_next,
    input  logic [7:0]       rc,
    output logic [BLK_W-1:0] rk_prev
);
    logic [WORD_W-1:0] n0, n1, n2, n3, p0, p1, p2, p3, rot, mixw;

    assign {n0, n1, n2, n3} = rk_next;
    assign p3  = n3 ^ n2;
    assign p2  = n2 ^ n1;
    assign p1  = n1 ^ n0;
    assign rot = {p3[23:0], p3[31:24]};

    // Substitute each byte of the recovered last word.
    for (genvar b = 0; b < 4; b++) begin : g_sub
        assign mixw[WORD_W-1-8*b -: 8] = sub_fwd(rot[WORD_W-1-8*b -: 8]);
    end

    assign p0      = n0 ^ mixw ^ {rc, 24'h0};
    assign rk_prev = {p0, p1, p2, p3};
endmodule

// File: rtl/aes_dec_round.sv
// Module: one inverse cipher round: row shift back, byte substitution back,
// key addition and, unless this is the last round, column unmixing.
// Purely combinational; the byte order is column-major, byte 0 in the top bits.
module aes_dec_round
    import aes_dec_pkg::*;
(
    input  logic [BLK_W-1:0] st,
    input  logic [BLK_W-1:0] rk,
    input  logic             last,
    output logic [BLK_W-1:0] nxt
);
    logic [7:0] mid [NUM_BYTES];

    for (genvar c = 0; c < 4; c++) begin : g_col
        for (genvar r = 0; r < 4; r++) begin : g_row
            localparam int SRC = 4 * ((c - r + 4) % 4) + r;
            localparam int DST = 4 * c + r;
            // Undo the row rotation, undo the substitution, add the key.
            assign mid[DST] = sub_inv(st[BLK_W-1-8*SRC -: 8]) ^ rk[BLK_W-1-8*DST -: 8];
            // Column unmix with coefficients 0e,0b,0d,09 rotated per row.
            assign nxt[BLK_W-1-8*DST -: 8] = last ? mid[DST] :
                (gf_mul(8'h0e, mid[4*c + r])           ^
                 gf_mul(8'h0b, mid[4*c + (r + 1) % 4]) ^
                 gf_mul(8'h0d, mid[4*c + (r + 2) % 4]) ^
                 gf_mul(8'h09, mid[4*c + (r + 3) % 4]));
        end
    end
endmodule

// File: rtl/aes128_decrypt.sv
// Module: AES-128 decryption engine top. The key phase is held in
// aes_dec_keyprep. The data phase sits here: an accepted load adds the final
// round key, then ten inverse rounds run, one per cycle, with round keys
// regenerated backwards. done pulses twelve cycles after load.
// Assumes single-cycle strobes; strobes during either phase are dropped.
module aes128_decrypt
    import aes_dec_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BLK_W-1:0] key,
    input  logic             key_load,
    output logic             key_done,
    input  logic [BLK_W-1:0] text_in,
    input  logic             load,
    output logic             done,
    output logic [BLK_W-1:0] text_out
);
    logic [BLK_W-1:0] final_key;
    logic [BLK_W-1:0] st, rk, rk_prev, st_nx;
    logic [CNT_W-1:0] dcnt;
    logic             key_ready, k_busy, d_busy, d_accept;

    aes_dec_keyprep u_keyprep (
        .clk       (clk),
        .rst_n     (rst_n),
        .key       (key),
        .key_load  (key_load),
        .data_busy (d_busy),
        .key_done  (key_done),
        .ready     (key_ready),
        .busy      (k_busy),
        .final_key (final_key)
    );

    aes_dec_keyback u_keyback (
        .rk_next (rk),
        .rc      (rcon_of(FINAL_CNT - dcnt)),
        .rk_prev (rk_prev)
    );

    aes_dec_round u_round (
        .st   (st),
        .rk   (rk_prev),
        .last (dcnt == LAST_RND),
        .nxt  (st_nx)
    );

    assign d_accept = load && key_ready && !k_busy && !d_busy;

    // Data-phase sequencing, state and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= '0;
            rk       <= '0;
            dcnt     <= '0;
            d_busy   <= 1'b0;
            done     <= 1'b0;
            text_out <= '0;
        end else begin
            done <= 1'b0;
            if (d_accept) begin
                st     <= text_in ^ final_key;
                rk     <= final_key;
                dcnt   <= CNT_W'(1);
                d_busy <= 1'b1;
            end else if (d_busy) begin
                if (dcnt <= LAST_RND) begin
                    st <= st_nx;
                    rk <= rk_prev;
                end
                if (dcnt == FINAL_CNT) begin
                    d_busy   <= 1'b0;
                    done     <= 1'b1;
                    text_out <= st;
                end
                dcnt <= dcnt + CNT_W'(1);
            end
        end
    end
endmodule

// Checker: phase timing and handshake properties of the engine.
module aes128_decrypt_chk (
    input logic clk,
    input logic rst_n,
    input logic key_load,
    input logic load,
    input logic key_done,
    input logic done,
    input logic k_busy,
    input logic d_busy,
    input logic key_ready
);
    logic [3:0] kc, dc;

    // Cycle counters started by accepted strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kc <= '0;
            dc <= '0;
        end else begin
            if (key_load && !k_busy && !d_busy) kc <= 4'd1;
            else if (kc == 4'd12)               kc <= 4'd0;
            else if (kc != 4'd0)                kc <= kc + 4'd1;
            if (load && key_ready && !k_busy && !d_busy) dc <= 4'd1;
            else if (dc == 4'd12)                        dc <= 4'd0;
            else if (dc != 4'd0)                         dc <= dc + 4'd1;
        end
    end

    // R2
    key_done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_done == (kc == 4'd12));
    // R2
    key_done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_done |=> !key_done);
    // R4
    done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done == (dc == 4'd12));
    // R4
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R3
    done_needs_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> key_ready);
    // R8
    phase_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(k_busy && d_busy));
endmodule

bind aes128_decrypt aes128_decrypt_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .key_load  (key_load),
    .load      (load),
    .key_done  (key_done),
    .done      (done),
    .k_busy    (k_busy),
    .d_busy    (d_busy),
    .key_ready (key_ready)
);

// File: tb/aes128_decrypt_tb.sv
`timescale 1ns/1ps
// Bench: encrypts with its own AES-128 model, feeds the ciphertext to the
// engine and compares the recovered plaintext and the handshake timing.
module aes128_decrypt_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [127:0] key = '0;
    logic         key_load = 1'b0;
    logic         key_done;
    logic [127:0] text_in = '0;
    logic         load = 1'b0;
    logic         done;
    logic [127:0] text_out;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] sb [256];

    always #4 clk = ~clk;

    aes128_decrypt u_dut (
        .clk(clk), .rst_n(rst_n), .key(key), .key_load(key_load), .key_done(key_done),
        .text_in(text_in), .load(load), .done(done), .text_out(text_out)
    );

    task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] m2(input logic [7:0] a);
        return a[7] ? ((a << 1) ^ 8'h1b) : (a << 1);
    endfunction

    function automatic logic [7:0] gm(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] p = 0;
        for (int i = 7; i >= 0; i--) begin
            p = m2(p);
            if (b[i]) p = p ^ a;
        end
        return p;
    endfunction

    function automatic logic [127:0] encrypt(input logic [127:0] k, input logic [127:0] pt);
        logic [31:0] w [44];
        logic [31:0] t;
        logic [7:0]  rc, s [16], u [16];
        logic [127:0] rk, out;
        rc = 8'h01;
        for (int i = 0; i < 4; i++) w[i] = k[127-32*i -: 32];
        for (int i = 4; i < 44; i++) begin
            t = w[i-1];
            if (i % 4 == 0) begin
                t = {sb[t[23:16]], sb[t[15:8]], sb[t[7:0]], sb[t[31:24]]} ^ {rc, 24'h0};
                rc = m2(rc);
            end
            w[i] = w[i-4] ^ t;
        end
        for (int i = 0; i < 16; i++) s[i] = pt[127-8*i -: 8] ^ w[i/4][31-8*(i%4) -: 8];
        for (int r = 1; r <= 10; r++) begin
            for (int i = 0; i < 16; i++) u[i] = sb[s[4*(((i/4) + (i%4)) % 4) + i%4]];
            for (int c = 0; c < 4; c++)
                for (int j = 0; j < 4; j++)
                    s[4*c+j] = (r == 10) ? u[4*c+j] :
                        gm(8'h02, u[4*c+j]) ^ gm(8'h03, u[4*c+(j+1)%4]) ^ u[4*c+(j+2)%4] ^ u[4*c+(j+3)%4];
            rk = {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]};
            for (int i = 0; i < 16; i++) s[i] = s[i] ^ rk[127-8*i -: 8];
        end
        for (int i = 0; i < 16; i++) out[127-8*i -: 8] = s[i];
        return out;
    endfunction

    // Key phase: strobe key_load, report first cycle of key_done and pulse count.
    task automatic preload(input logic [127:0] k, input bit poke, output int lat, output int cnt, output int dn);
        @(negedge clk); key = k; key_load = 1'b1;
        @(negedge clk); key_load = 1'b0;
        lat = -1; cnt = 0; dn = 0;
        for (int m = 1; m <= 20; m++) begin
            if (poke && m == 3) begin load = 1'b1; text_in = ~k; end
            if (poke && m == 4) load = 1'b0;
            @(negedge clk);
            if (key_done) begin cnt++; if (lat < 0) lat = m; end
            if (done) dn++;
        end
    endtask

    // Data phase: strobe load, capture text_out at done.
    task automatic decrypt(input logic [127:0] ct, input bit poke, output logic [127:0] res, output int lat, output int cnt);
        @(negedge clk); text_in = ct; load = 1'b1;
        @(negedge clk); load = 1'b0;
        lat = -1; cnt = 0; res = '0;
        for (int m = 1; m <= 20; m++) begin
            if (poke && m == 4) begin load = 1'b1; text_in = ~ct; key_load = 1'b1; key = ~ct; end
            if (poke && m == 5) begin load = 1'b0; key_load = 1'b0; end
            @(negedge clk);
            if (done) begin cnt++; if (lat < 0) begin lat = m; res = text_out; end end
        end
    endtask

    initial begin
        #(8 * 190000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [127:0] k, pt, ct, res, hold;
        int lat, cnt, dn;
        // Build the substitution table by searching inverses.
        for (int a = 0; a < 256; a++) begin
            logic [7:0] v;
            v = 8'h00;
            for (int b = 1; b < 256; b++) if (gm(8'(a), 8'(b)) == 8'h01) v = 8'(b);
            sb[a] = v ^ {v[6:0], v[7]} ^ {v[5:0], v[7:6]} ^ {v[4:0], v[7:5]} ^ {v[3:0], v[7:4]} ^ 8'h63;
        end

        repeat (3) @(negedge clk);
        // R1: reset values
        check(key_done == 0 && done == 0 && text_out == 0, "R1 reset", {text_out[125:0], key_done, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(key_done == 0 && done == 0 && text_out == 0, "R1 after reset", {text_out[125:0], key_done, done}, 0);

        // R3: load with no key ever preloaded
        decrypt(128'h1234, 0, res, lat, cnt);
        check(cnt == 0, "R3 load before key", cnt, 0);

        // Model self-check against the published vector, then R2 and R5.
        k  = 128'h000102030405060708090a0b0c0d0e0f;
        pt = 128'h00112233445566778899aabbccddeeff;
        ct = encrypt(k, pt);
        check(ct == 128'h69c4e0d86a7b0430d8cdb78070b4c55a, "R5 model vector", ct, 128'h69c4e0d86a7b0430d8cdb78070b4c55a);
        preload(k, 0, lat, cnt, dn);
        check(lat == 11, "R2 key_done latency", lat, 11);
        check(cnt == 1, "R2 key_done width", cnt, 1);
        decrypt(ct, 0, res, lat, cnt);
        check(lat == 11, "R4 done latency", lat, 11);
        check(cnt == 1, "R4 done width", cnt, 1);
        check(res == pt, "R5 known vector", res, pt);
        @(negedge clk);
        check(text_out == pt, "R4 text_out held", text_out, pt);

        // R6 and R7: sweep several keys, several blocks per key.
        for (int ki = 0; ki < 5; ki++) begin
            k = {4{32'h9e3779b9 * (ki + 1)}} ^ {32'(ki), 96'h0f1e2d3c4b5a69788796a5b4};
            preload(k, 0, lat, cnt, dn);
            check(lat == 11 && cnt == 1, "R7 new key handshake", lat, 11);
            for (int bi = 0; bi < 5; bi++) begin
                pt = {4{32'h85ebca6b * (bi + 3) + 32'(ki)}} ^ (128'h1 << (ki * 25 + bi));
                ct = encrypt(k, pt);
                decrypt(ct, 0, res, lat, cnt);
                check(res == pt && cnt == 1, bi == 0 ? "R7 decrypt under new key" : "R6 repeated block", res, pt);
            end
        end

        // R8: strobes during a data phase are ignored.
        pt = 128'hfedcba98765432100123456789abcdef;
        ct = encrypt(k, pt);
        decrypt(ct, 1, res, lat, cnt);
        check(res == pt && cnt == 1 && lat == 11, "R8 strobes during data", res, pt);
        key = '0;
        decrypt(ct, 0, res, lat, cnt);
        check(res == pt, "R8 held key unchanged", res, pt);

        // R3 again: load during a fresh key phase is ignored; R8 for key phase.
        k = 128'h2b7e151628aed2a6abf7158809cf4f3c;
        preload(k, 1, lat, cnt, dn);
        check(dn == 0, "R3 load during key phase", dn, 0);
        check(lat == 11 && cnt == 1, "R8 key phase undisturbed", lat, 11);
        pt = 128'h6bc1bee22e409f96e93d7e117393172a;
        ct = encrypt(k, pt);
        decrypt(ct, 0, res, lat, cnt);
        check(res == pt, "R7 second key vector", res, pt);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule